// File: doc/BRIEF.md
# Multi-core inter-processor interrupt controller

This block keeps one small interrupt register set for each of `NCORE` processor cores, and it drives one interrupt line per core. A register set has a status word and an enable word. It also has two write-only ports, one that sets status bits and one that clears them, and a bank of mailbox words that software uses to pass data alongside an interrupt. Every access on the shared 32-bit little-endian register port carries a requester ID. That ID selects the register set the access touches, so each core reaches only its own set through the same offsets.

A core interrupts another core by writing the send register. The value it writes holds a target core ID and a 5-bit vector. The block turns the vector into a one-hot value and sets that bit in the target core's status, exactly as a set-port write from the target core would. Target core IDs map to core indices one to one. A requester or target ID at or above `NCORE` is refused with a decode error.

The access port has no back-pressure. An access is taken in every cycle that `acc_en` is high. The response (read data and error flag) is combinational and belongs to the same cycle. Register writes and interrupt line changes take effect at the next clock edge.

Top module: `ipi_ctrl`

## Requirements
- R1: After reset, every status, enable and mailbox word reads as zero and every interrupt line is low.
- R2: A write to the set port (offset 0x08) ORs the value into the requester's status. If the new status ANDed with enable is nonzero, that core's interrupt line goes high on the next clock edge. Otherwise the line keeps its level.
- R3: A write to the clear port (offset 0x0C) removes the written bits from status. The interrupt line goes low only if the new status is zero and enable is nonzero. In every other case it keeps its level.
- R4: Status (offset 0x00) is read-only, and a write to it changes nothing. The set and clear ports always read as zero.
- R5: Enable (offset 0x04) can be read and written. Writing it never changes the interrupt line by itself.
- R6: The mailbox words sit at offsets 0x20 + 4·k for k = 0..7. Each can be read and written, and each core has its own copy.
- R7: Register decode uses only bits 7:0 of the access offset. Higher offset bits are ignored, so offset 0x104 selects the enable word.
- R8: A write to the send register (offset 0x40) takes the target core ID from bits 25:16 and the vector from bits 4:0. It sets status bit `vector` on the target core, and the interrupt line follows the R2 rule. The send register reads as zero.
- R9: A send write whose target ID is at or above `NCORE` returns `rsp_err` = 1 in the same cycle and changes no state.
- R10: An access whose requester ID is at or above `NCORE` returns `rsp_err` = 1 and read data 0 in the same cycle, and it changes no state.
- R11: An offset that decodes to no register reads as zero, ignores writes, and returns no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| acc_en | input | 1 | Access present this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_id | input | CID_W (10) | Requester core ID |
| acc_off | input | OFF_W (12) | Byte offset of the access |
| acc_wdata | input | DATA_W (32) | Write data |
| rsp_rdata | output | DATA_W (32) | Read data, same cycle |
| rsp_err | output | 1 | Decode error, same cycle |
| irq_o | output | NCORE (4) | Interrupt line per core |

## Verification
The set/clear interrupt rule is tried with four kinds of case. Set bits are written under disabled enable bits, to show that status alone does not raise a line. A partial clear is tried, to show that the line holds while status is nonzero. A full clear is tried once with enable zero and once with enable nonzero. Enable is also rewritten while the line is high. Sends go to the last valid core, to the first invalid core and to every vector value. These cases separate correct target decoding and one-hot expansion from off-by-one mistakes. A long seeded random mix of requester IDs (both in and out of range), offsets (including aliased and unmapped ones) and data is checked against a bench model. That mix shows whether the per-core state stays separate across cores.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam logic [7:0] OFF_STAT = 8'h00;
  localparam logic [7:0] OFF_EN   = 8'h04;
  localparam logic [7:0] OFF_SET  = 8'h08;
  localparam logic [7:0] OFF_CLR  = 8'h0C;
  localparam logic [7:0] OFF_MB   = 8'h20;
  localparam logic [7:0] OFF_SEND = 8'h40;
  localparam int         TGT_LSB  = 16;

  typedef enum logic [2:0] {
    K_NONE, K_STAT, K_EN, K_SET, K_CLR, K_MB, K_SEND
  } reg_kind_e;
endpackage

// File: rtl/ipi_decode.sv
module ipi_decode
  import ipi_pkg::*;
#(
  parameter int NCORE    = 4,
  parameter int DATA_W   = 32,
  parameter int MB_WORDS = 8,
  parameter int CID_W    = 10,
  parameter int OFF_W    = 12,
  localparam int MBI_W   = (MB_WORDS > 1) ? $clog2(MB_WORDS) : 1,
  localparam int VEC_W   = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [CID_W-1:0]  acc_id,
  input  logic [OFF_W-1:0]  acc_off,
  input  logic [DATA_W-1:0] acc_wdata,
  output reg_kind_e         kind,
  output logic [MBI_W-1:0]  mb_idx,
  output logic              src_ok,
  output logic              err,
  output logic [NCORE-1:0]  en_we,
  output logic [NCORE-1:0]  set_we,
  output logic [NCORE-1:0]  clr_we,
  output logic [NCORE-1:0]  mb_we,
  output logic [DATA_W-1:0] set_data
);
  logic [7:0]       lo;
  logic [7:0]       mb_rel;
  logic [CID_W-1:0] tgt;
  logic [VEC_W-1:0] vec;
  logic             tgt_ok;
  logic             go;
  logic             unused_off;

  assign lo         = acc_off[7:0];
  assign unused_off = ^acc_off[OFF_W-1:8];
  assign mb_rel     = lo - OFF_MB;
  assign mb_idx     = mb_rel[MBI_W+1:2];
  assign tgt        = acc_wdata[TGT_LSB +: CID_W];
  assign vec        = acc_wdata[VEC_W-1:0];

  always_comb begin
    if (lo == OFF_STAT)                                        kind = K_STAT;
    else if (lo == OFF_EN)                                     kind = K_EN;
    else if (lo == OFF_SET)                                    kind = K_SET;
    else if (lo == OFF_CLR)                                    kind = K_CLR;
    else if (lo == OFF_SEND)                                   kind = K_SEND;
    else if (lo >= OFF_MB && int'(mb_rel) < 4 * MB_WORDS)      kind = K_MB;
    else                                                       kind = K_NONE;
  end

  assign src_ok   = ({1'b0, acc_id} < (CID_W+1)'(NCORE));
  assign tgt_ok   = ({1'b0, tgt} < (CID_W+1)'(NCORE));
  assign err      = acc_en && (!src_ok || (acc_wr && kind == K_SEND && !tgt_ok));
  assign go       = acc_en && acc_wr && !err;
  assign set_data = (kind == K_SEND) ? (DATA_W'(1) << vec) : acc_wdata;

  for (genvar i = 0; i < NCORE; i++) begin : g_we
    logic own;
    assign own      = (acc_id == CID_W'(i));
    assign en_we[i] = go && own && kind == K_EN;
    assign clr_we[i] = go && own && kind == K_CLR;
    assign mb_we[i] = go && own && kind == K_MB;
    assign set_we[i] = go && ((own && kind == K_SET) ||
                              (kind == K_SEND && tgt == CID_W'(i)));
  end

  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ((en_we | set_we | clr_we | mb_we) == '0));  // R9
  AST_SET_ONE_CORE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_we));  // R8
endmodule

// File: rtl/ipi_core.sv
module ipi_core #(
  parameter int DATA_W   = 32,
  parameter int MB_WORDS = 8,
  localparam int MBI_W   = (MB_WORDS > 1) ? $clog2(MB_WORDS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en_we,
  input  logic                       set_we,
  input  logic                       clr_we,
  input  logic                       mb_we,
  input  logic [MBI_W-1:0]           mb_idx,
  input  logic [DATA_W-1:0]          wdata,
  input  logic [DATA_W-1:0]          set_data,
  output logic [DATA_W-1:0]          status,
  output logic [DATA_W-1:0]          enable,
  output logic [MB_WORDS*DATA_W-1:0] mb_flat,
  output logic                       irq
);
  logic [DATA_W-1:0] mb_q [MB_WORDS];
  logic [DATA_W-1:0] stat_set, stat_clr;

  assign stat_set = status | set_data;
  assign stat_clr = status & ~wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      enable <= '0;
      irq    <= 1'b0;
    end else begin
      if (en_we) enable <= wdata;
      if (set_we) begin
        status <= stat_set;
        if ((stat_set & enable) != '0) irq <= 1'b1;
      end else if (clr_we) begin
        status <= stat_clr;
        if (stat_clr == '0 && enable != '0) irq <= 1'b0;
      end
    end
  end

  for (genvar k = 0; k < MB_WORDS; k++) begin : g_mb
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               mb_q[k] <= '0;
      else if (mb_we && mb_idx == MBI_W'(k))    mb_q[k] <= wdata;
    end
    assign mb_flat[k*DATA_W +: DATA_W] = mb_q[k];
  end

  AST_IRQ_RISE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(set_we));  // R2
  AST_IRQ_FALL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> ($past(clr_we) && status == '0));  // R3
  AST_STATUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we) |=> $stable(status));  // R4
  AST_EN_KEEPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (en_we && !set_we && !clr_we) |=> $stable(irq));  // R5
endmodule

// File: rtl/ipi_ctrl.sv
module ipi_ctrl
  import ipi_pkg::*;
#(
  parameter int NCORE    = 4,
  parameter int DATA_W   = 32,
  parameter int MB_WORDS = 8,
  parameter int CID_W    = 10,
  parameter int OFF_W    = 12,
  localparam int MBI_W   = (MB_WORDS > 1) ? $clog2(MB_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [CID_W-1:0]  acc_id,
  input  logic [OFF_W-1:0]  acc_off,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic [NCORE-1:0]  irq_o
);
  reg_kind_e          kind;
  logic [MBI_W-1:0]   mb_idx;
  logic               src_ok;
  logic [NCORE-1:0]   en_we, set_we, clr_we, mb_we;
  logic [DATA_W-1:0]  set_data;
  logic [DATA_W-1:0]  stat_a [NCORE];
  logic [DATA_W-1:0]  en_a   [NCORE];
  logic [MB_WORDS*DATA_W-1:0] mb_a [NCORE];

  ipi_decode #(
    .NCORE(NCORE), .DATA_W(DATA_W), .MB_WORDS(MB_WORDS),
    .CID_W(CID_W), .OFF_W(OFF_W)
  ) i_dec (
    .clk(clk), .rst_n(rst_n),
    .acc_en(acc_en), .acc_wr(acc_wr), .acc_id(acc_id),
    .acc_off(acc_off), .acc_wdata(acc_wdata),
    .kind(kind), .mb_idx(mb_idx), .src_ok(src_ok), .err(rsp_err),
    .en_we(en_we), .set_we(set_we), .clr_we(clr_we), .mb_we(mb_we),
    .set_data(set_data)
  );

  for (genvar i = 0; i < NCORE; i++) begin : g_core
    ipi_core #(.DATA_W(DATA_W), .MB_WORDS(MB_WORDS)) i_core (
      .clk(clk), .rst_n(rst_n),
      .en_we(en_we[i]), .set_we(set_we[i]), .clr_we(clr_we[i]),
      .mb_we(mb_we[i]), .mb_idx(mb_idx), .wdata(acc_wdata),
      .set_data(set_data),
      .status(stat_a[i]), .enable(en_a[i]), .mb_flat(mb_a[i]),
      .irq(irq_o[i])
    );
  end

  always_comb begin
    rsp_rdata = '0;
    if (acc_en && !acc_wr && src_ok) begin
      for (int i = 0; i < NCORE; i++) begin
        if (acc_id == CID_W'(i)) begin
          case (kind)
            K_STAT:  rsp_rdata = stat_a[i];
            K_EN:    rsp_rdata = en_a[i];
            K_MB:    rsp_rdata = mb_a[i][mb_idx*DATA_W +: DATA_W];
            default: rsp_rdata = '0;
          endcase
        end
      end
    end
  end

  AST_BAD_REQ_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !src_ok) |-> (rsp_err && rsp_rdata == '0));  // R10
  AST_ERR_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && rsp_err) |=> $stable(irq_o));  // R9
endmodule

// File: tb/test_ipi_ctrl.sv
module test_ipi_ctrl;
  localparam int N = 4;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        acc_en = 0, acc_wr = 0;
  logic [9:0]  acc_id = 0;
  logic [11:0] acc_off = 0;
  logic [31:0] acc_wdata = 0;
  logic [31:0] rsp_rdata;
  logic        rsp_err;
  logic [N-1:0] irq_o;

  int checks = 0, errors = 0;

  logic [31:0] m_stat [N];
  logic [31:0] m_en   [N];
  logic [31:0] m_mb   [N][8];
  logic [N-1:0] m_irq;

  always #5 clk = ~clk;

  ipi_ctrl #(.NCORE(N)) i_ipi_ctrl (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_id(acc_id), .acc_off(acc_off), .acc_wdata(acc_wdata),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic bit exp_err(input bit wr, input int id, input logic [11:0] off,
                                 input logic [31:0] d);
    return (id >= N) || (wr && off[7:0] == 8'h40 && int'(d[25:16]) >= N);
  endfunction

  function automatic logic [31:0] exp_rd(input int id, input logic [11:0] off);
    logic [7:0] lo = off[7:0];
    if (id >= N) return 0;
    if (lo == 8'h00) return m_stat[id];
    if (lo == 8'h04) return m_en[id];
    if (lo >= 8'h20 && lo <= 8'h3F) return m_mb[id][lo[4:2]];
    return 0;
  endfunction

  function automatic void m_set(input int c, input logic [31:0] v);
    m_stat[c] |= v;
    if ((m_stat[c] & m_en[c]) != 0) m_irq[c] = 1'b1;
  endfunction

  function automatic void m_write(input int id, input logic [11:0] off, input logic [31:0] d);
    logic [7:0] lo = off[7:0];
    if (exp_err(1'b1, id, off, d)) return;
    if (lo == 8'h04) m_en[id] = d;
    else if (lo == 8'h08) m_set(id, d);
    else if (lo == 8'h0C) begin
      m_stat[id] &= ~d;
      if (m_stat[id] == 0 && m_en[id] != 0) m_irq[id] = 1'b0;
    end
    else if (lo >= 8'h20 && lo <= 8'h3F) m_mb[id][lo[4:2]] = d;
    else if (lo == 8'h40) m_set(int'(d[25:16]), 32'd1 << d[4:0]);
  endfunction

  task automatic acc(input bit wr, input int id, input logic [11:0] off,
                     input logic [31:0] d, input string tag);
    logic [31:0] rd;
    logic        er;
    @(negedge clk);
    acc_en = 1; acc_wr = wr; acc_id = 10'(id); acc_off = off; acc_wdata = d;
    #1;
    rd = rsp_rdata; er = rsp_err;
    chk(er == exp_err(wr, id, off, d), tag, "rsp_err", 32'(er), 32'(exp_err(wr, id, off, d)));
    if (!wr) chk(rd == exp_rd(id, off), tag, "rdata", rd, exp_rd(id, off));
    @(posedge clk);
    #1;
    acc_en = 0;
    if (wr) m_write(id, off, d);
    chk(irq_o == m_irq, tag, "irq_o", 32'(irq_o), 32'(m_irq));
  endtask

  function automatic logic [31:0] send_word(input int tgt, input int vec);
    return (32'(tgt) << 16) | 32'(vec);
  endfunction

  task automatic sweep(input string tag);
    for (int c = 0; c < N; c++) begin
      acc(0, c, 12'h000, 0, tag);
      acc(0, c, 12'h004, 0, tag);
      for (int k = 0; k < 8; k++) acc(0, c, 12'(8'h20 + 4*k), 0, tag);
    end
  endtask

  task automatic run_all();
    int oid, ooff, vec;
    logic [11:0] offs [10];
    offs = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h020, 12'h03C,
             12'h040, 12'h010, 12'h044, 12'h104};
    for (int c = 0; c < N; c++) begin
      m_stat[c] = 0; m_en[c] = 0;
      for (int k = 0; k < 8; k++) m_mb[c][k] = 0;
    end
    m_irq = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    #1;
    chk(irq_o == 0, "R1", "irq after reset", 32'(irq_o), 0);
    sweep("R1");

    acc(1, 0, 12'h004, 32'h1, "R5");          // enable alone keeps irq low
    acc(1, 0, 12'h008, 32'h2, "R2");          // status & enable == 0, irq low
    acc(1, 0, 12'h008, 32'h1, "R2");          // irq rises
    acc(0, 0, 12'h008, 0, "R4");              // set port reads 0
    acc(0, 0, 12'h00C, 0, "R4");              // clear port reads 0
    acc(1, 0, 12'h000, 32'hFFFF_FFFF, "R4");  // status write ignored
    acc(0, 0, 12'h000, 0, "R4");
    acc(1, 0, 12'h00C, 32'h1, "R3");          // partial clear, irq holds
    acc(1, 0, 12'h00C, 32'h2, "R3");          // full clear, irq drops
    acc(1, 0, 12'h008, 32'h1, "R2");
    acc(1, 0, 12'h004, 32'h0, "R5");          // disable while high, irq holds
    acc(1, 0, 12'h00C, 32'h1, "R3");          // status 0 but enable 0: holds
    acc(1, 0, 12'h004, 32'h8, "R5");
    acc(1, 0, 12'h00C, 32'h0, "R3");          // status 0, enable set: drops

    for (int c = 0; c < N; c++)
      for (int k = 0; k < 8; k++) acc(1, c, 12'(8'h20 + 4*k), 32'hA000_0000 + 32'(c*16 + k), "R6");
    acc(0, 2, 12'h03C, 0, "R6");
    acc(1, 1, 12'h124, 32'h5555_AAAA, "R7");  // aliases mailbox word 1
    acc(0, 1, 12'hF24, 0, "R7");
    acc(1, 3, 12'h304, 32'h8000_0000, "R7");  // aliases enable
    acc(0, 3, 12'h004, 0, "R7");

    acc(1, 1, 12'h040, send_word(N-1, 31), "R8");
    acc(0, N-1, 12'h000, 0, "R8");
    acc(0, 1, 12'h040, 0, "R8");
    acc(1, 0, 12'h040, send_word(N, 3), "R9");
    acc(1, 0, 12'h040, send_word(1023, 0), "R9");
    acc(0, 0, 12'h000, 0, "R9");
    acc(0, N, 12'h004, 0, "R10");
    acc(1, N, 12'h008, 32'hFFFF_FFFF, "R10");
    acc(1, 1023, 12'h020, 32'h1234_5678, "R10");
    acc(1, 2, 12'h010, 32'hFFFF_FFFF, "R11");
    acc(0, 2, 12'h010, 0, "R11");
    acc(0, 2, 12'h044, 0, "R11");
    acc(0, 2, 12'h080, 0, "R11");
    sweep("R10");

    for (int v = 0; v < 32; v++) acc(1, v % N, 12'h040, send_word((v + 1) % N, v), "R8");
    sweep("R8");

    for (int n = 0; n < 1500; n++) begin
      oid  = ($urandom % 8 == 0) ? N + int'($urandom % 3) : int'($urandom % N);
      ooff = int'($urandom % 10);
      if (offs[ooff] == 12'h040) begin
        vec = int'($urandom % 32);
        acc(1, oid, offs[ooff], send_word(int'($urandom % (N + 2)), vec), "R8");
      end else if (offs[ooff] == 12'h00C) begin
        acc($urandom % 2, oid, offs[ooff], $urandom & $urandom, "R3");
      end else begin
        acc($urandom % 2, oid, offs[ooff] | 12'(($urandom % 4) << 8), $urandom, "R2");
      end
    end
    sweep("R6");
  endtask

  initial begin
    void'($urandom(32'd13579));
    fork
      run_all();
      begin
        #(1_500_000);
        errors++;
        $display("FAIL ALL watchdog actual=running expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule